// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Bank

This block gathers up to 32 interrupt sources per bank across a parameterized number of banks. It detects edges on each source and latches them into pending status. Two host-side interrupt outputs are produced from that status. Each output line has its own status and its own mask, so two independent hosts can serve the same sources. Each host acknowledges interrupts on its own line without disturbing the other. The edge-select configuration is common to both lines.

Access goes through a simple byte-wide register bus that is synchronous to `clk`. Per bank, a control bit selects how status is acknowledged: either the act of reading a status byte clears the bits it returned, or software writes ones to the bits it wants cleared. A small primary summary register per line tells a host which banks have an unmasked pending source on that line. This avoids polling every bank.

Top module: `dl_irq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1, every status bit reads 0, every edge field reads 00, the control bit reads 0, both primary bytes read 0x00 and both `irq_n` bits are 1. Mask bits above the implemented source count read 0.
- R2: Source j of a bank has a two-bit edge field in edge byte j/4 at bits (j mod 4)*2+1 and (j mod 4)*2. Setting the higher bit makes a 0-to-1 transition pending. Setting the lower bit makes a 1-to-0 transition pending. The value 11 makes both pending.
- R3: A source whose edge field is 00 never becomes pending on either line, whatever its input does.
- R4: A single edge-select setting serves both lines. A qualifying edge sets the same status bit on line 0 and on line 1.
- R5: `irq_n[L]` is active low. It is 0 exactly when some status bit of line L is 1 and the corresponding mask bit of line L is 0. A mask bit of 1 hides that source from line L. With all mask bits set, the line stays at 1.
- R6: Each line's status and mask are separate. Clearing or masking a bit on one line does not change the other line.
- R7: With the control bit at 0, writing 1 to a status bit clears it and writing 0 leaves it unchanged. Reads do not clear status.
- R8: With the control bit at 1, a read of a status byte clears the bits that the read returned. Writes to status bytes are ignored.
- R9: If an edge arrives in the same cycle as a clearing read or a clearing write of its status bit, the bit stays pending.
- R10: The address of bank b starts at b*32. Its offsets are: line 0 status 0..3, line 1 status 4..7, line 0 mask 8..11, line 1 mask 12..15, edge select 16..23, and control 24 (bit 0 selects clear-on-read). Status and mask bytes are little-endian, with source j in byte j/8, bit j mod 8.
- R11: The primary byte of line L sits at address NUM_BANKS*32+L. Its bit b is 1 when bank b has a status bit set with mask 0 on line L.
- R12: Read data is captured at the clock edge where `bus_rd` is 1 and appears after that edge. It holds until the next read. A source transition is recognised at the first clock edge where `src_in` differs from its value at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_in | input | NUM_BANKS*SRC_PER_BANK | Interrupt source levels, synchronous to clk |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; clears status in clear-on-read mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 2 | Active-low interrupt per line |

## Verification
The bench sweeps every source of both banks through all four edge codes. For each source it drives a rising and then a falling transition. A wrong field position or swapped polarity bits would make the wrong bit, the wrong byte or the wrong edge show as pending. A 00 code that leaked edges would show a pending bit. The bench also drives an edge in the very cycle of a clearing read and of a clearing write. A design that lets the clear win would lose that interrupt. Further checks cover masking on one line only, acknowledgment on one line only, and writes that are ignored in clear-on-read mode. A design that shared state between lines would clear or raise the wrong line. A design that honoured writes in clear-on-read mode would clear status too early.

// File: rtl/dl_irq_pkg.sv
package dl_irq_pkg;

  localparam int BANK_AW   = 5;
  localparam int BANK_SPAN = 1 << BANK_AW;
  localparam int MAX_SRC   = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_STAT,
    RG_MASK,
    RG_EDGE,
    RG_CTRL
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic        ln;
    logic [2:0]  idx;
  } reg_sel_t;

  // Offset layout inside one bank: status 0..7, mask 8..15, edge 16..23, ctrl 24
  function automatic reg_sel_t decode_off(input logic [BANK_AW-1:0] off);
    reg_sel_t r;
    r.kind = RG_NONE;
    r.ln   = 1'b0;
    r.idx  = 3'd0;
    if (!off[4]) begin
      r.kind = off[3] ? RG_MASK : RG_STAT;
      r.ln   = off[2];
      r.idx  = {1'b0, off[1:0]};
    end else if (!off[3]) begin
      r.kind = RG_EDGE;
      r.idx  = off[2:0];
    end else if (off[2:0] == 3'd0) begin
      r.kind = RG_CTRL;
    end
    return r;
  endfunction

endpackage

// File: rtl/dl_irq_edge.sv
module dl_irq_edge #(
  parameter int SRC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC-1:0]   src_in,
  input  logic             we,
  input  logic [2:0]       idx,
  input  logic [7:0]       wdata,
  output logic [2*SRC-1:0] cfg_q,
  output logic [SRC-1:0]   evt
);

  localparam int CFG_W = 2 * SRC;

  logic [CFG_W-1:0] cfg_r, cfg_n;
  logic [SRC-1:0]   prev_r;

  always_comb begin
    cfg_n = cfg_r;
    for (int b = 0; b < CFG_W; b++) begin
      if (idx == 3'(b / 8)) cfg_n[b] = wdata[b % 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r  <= '0;
      prev_r <= '0;
    end else begin
      if (we) cfg_r <= cfg_n;
      prev_r <= src_in;
    end
  end

  // Upper field bit arms the rising edge, lower bit the falling edge
  for (genvar i = 0; i < SRC; i++) begin : g_det
    logic rise, fall;
    assign rise   = src_in[i] & ~prev_r[i];
    assign fall   = ~src_in[i] & prev_r[i];
    assign evt[i] = (cfg_r[2*i+1] & rise) | (cfg_r[2*i] & fall);
  end

  assign cfg_q = cfg_r;

endmodule

// File: rtl/dl_irq_line.sv
module dl_irq_line #(
  parameter int SRC = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SRC-1:0] evt,
  input  logic           cor,
  input  logic           stat_wr,
  input  logic           stat_rd,
  input  logic           mask_wr,
  input  logic [1:0]     idx,
  input  logic [7:0]     wdata,
  output logic [SRC-1:0] stat_q,
  output logic [SRC-1:0] mask_q
);

  logic [SRC-1:0] stat_r, stat_n;
  logic [SRC-1:0] mask_r, mask_n;
  logic [SRC-1:0] clr;

  always_comb begin
    clr    = '0;
    mask_n = mask_r;
    for (int i = 0; i < SRC; i++) begin
      if (idx == 2'(i / 8)) begin
        if (stat_rd && cor)  clr[i]    = stat_r[i];
        if (stat_wr && !cor) clr[i]    = wdata[i % 8];
        if (mask_wr)         mask_n[i] = wdata[i % 8];
      end
    end
    // a fresh edge outranks any clear in the same cycle
    stat_n = (stat_r & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_r <= '0;
      mask_r <= '1;
    end else begin
      stat_r <= stat_n;
      if (mask_wr) mask_r <= mask_n;
    end
  end

  assign stat_q = stat_r;
  assign mask_q = mask_r;

endmodule

// File: rtl/dl_irq_bank.sv
module dl_irq_bank
  import dl_irq_pkg::*;
#(
  parameter int SRC = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SRC-1:0]         src_in,
  input  logic                   sel,
  input  logic [BANK_AW-1:0]     off,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [1:0][SRC-1:0]    stat_q,
  output logic [1:0][SRC-1:0]    mask_q,
  output logic [2*SRC-1:0]       cfg_q
);

  reg_sel_t       rs;
  logic [SRC-1:0] evt;
  logic [SRC-1:0] st [2];
  logic [SRC-1:0] mk [2];
  logic           cor_r, cor_n;
  logic           edge_we, ctrl_we;

  always_comb rs = decode_off(off);

  assign edge_we = sel && wr && (rs.kind == RG_EDGE);
  assign ctrl_we = sel && wr && (rs.kind == RG_CTRL);

  dl_irq_edge #(.SRC(SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_in (src_in),
    .we     (edge_we),
    .idx    (rs.idx),
    .wdata  (wdata),
    .cfg_q  (cfg_q),
    .evt    (evt)
  );

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic hit_stat, hit_mask;
    assign hit_stat = sel && (rs.kind == RG_STAT) && (rs.ln == 1'(l));
    assign hit_mask = sel && (rs.kind == RG_MASK) && (rs.ln == 1'(l));

    dl_irq_line #(.SRC(SRC)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .cor     (cor_r),
      .stat_wr (hit_stat && wr),
      .stat_rd (hit_stat && rd),
      .mask_wr (hit_mask && wr),
      .idx     (rs.idx[1:0]),
      .wdata   (wdata),
      .stat_q  (st[l]),
      .mask_q  (mk[l])
    );
  end

  assign stat_q = {st[1], st[0]};
  assign mask_q = {mk[1], mk[0]};

  always_comb cor_n = ctrl_we ? wdata[0] : cor_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cor_r <= 1'b0;
    else if (ctrl_we) cor_r <= cor_n;
  end

  always_comb begin
    rdata = '0;
    unique case (rs.kind)
      RG_STAT: begin
        for (int i = 0; i < SRC; i++)
          if (rs.idx == 3'(i / 8)) rdata[i % 8] = st[rs.ln][i];
      end
      RG_MASK: begin
        for (int i = 0; i < SRC; i++)
          if (rs.idx == 3'(i / 8)) rdata[i % 8] = mk[rs.ln][i];
      end
      RG_EDGE: begin
        for (int b = 0; b < 2*SRC; b++)
          if (rs.idx == 3'(b / 8)) rdata[b % 8] = cfg_q[b];
      end
      RG_CTRL: rdata = {7'd0, cor_r};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/dl_irq_ctrl.sv
module dl_irq_ctrl
  import dl_irq_pkg::*;
#(
  parameter int NUM_BANKS    = 2,
  parameter int SRC_PER_BANK = 24,
  parameter int ADDR_W       = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_in,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [7:0]                        bus_wdata,
  output logic [7:0]                        bus_rdata,
  output logic [1:0]                        irq_n
);

  localparam int TOT      = NUM_BANKS * SRC_PER_BANK;
  localparam int S        = SRC_PER_BANK;
  localparam int BSEL_W   = ADDR_W - BANK_AW;
  localparam int PRI_ADDR = NUM_BANKS * BANK_SPAN;

  // reset: asserted at once, released after two clock edges
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [NUM_BANKS-1:0]  bank_sel;
  logic [1:0]            pri_sel;
  logic [7:0]            bk_rdata [NUM_BANKS];
  logic [1:0][S-1:0]     bk_stat  [NUM_BANKS];
  logic [1:0][S-1:0]     bk_mask  [NUM_BANKS];
  logic [2*S-1:0]        bk_cfg   [NUM_BANKS];

  wire [TOT-1:0]   stat_l0_all, stat_l1_all, mask_l0_all, mask_l1_all;
  wire [2*TOT-1:0] cfg_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel[b] = (bus_addr[ADDR_W-1:BANK_AW] == BSEL_W'(b));

    dl_irq_bank #(.SRC(S)) u_bank (
      .clk    (clk),
      .rst_n  (rst_q),
      .src_in (src_in[b*S +: S]),
      .sel    (bank_sel[b]),
      .off    (bus_addr[BANK_AW-1:0]),
      .wr     (bus_wr),
      .rd     (bus_rd),
      .wdata  (bus_wdata),
      .rdata  (bk_rdata[b]),
      .stat_q (bk_stat[b]),
      .mask_q (bk_mask[b]),
      .cfg_q  (bk_cfg[b])
    );

    assign stat_l0_all[b*S +: S]     = bk_stat[b][0];
    assign stat_l1_all[b*S +: S]     = bk_stat[b][1];
    assign mask_l0_all[b*S +: S]     = bk_mask[b][0];
    assign mask_l1_all[b*S +: S]     = bk_mask[b][1];
    assign cfg_all[b*2*S +: 2*S]     = bk_cfg[b];
  end

  for (genvar l = 0; l < 2; l++) begin : g_pri_sel
    assign pri_sel[l] = (bus_addr == ADDR_W'(PRI_ADDR + l));
  end

  // primary summary: one bit per bank per line
  logic [1:0][NUM_BANKS-1:0] pri;
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      pri[0][b] = |(stat_l0_all[b*S +: S] & ~mask_l0_all[b*S +: S]);
      pri[1][b] = |(stat_l1_all[b*S +: S] & ~mask_l1_all[b*S +: S]);
    end
  end

  assign irq_n[0] = ~|pri[0];
  assign irq_n[1] = ~|pri[1];

  logic [7:0] rd_mux, rdata_r;
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel[b]) rd_mux = bk_rdata[b];
    for (int l = 0; l < 2; l++)
      if (pri_sel[l]) rd_mux = 8'(pri[l]);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) rdata_r <= '0;
    else if (bus_rd) rdata_r <= rd_mux;
  end

  assign bus_rdata = rdata_r;

endmodule

// File: rtl/dl_irq_chk.sv
module dl_irq_chk #(
  parameter int TOT = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [1:0]       irq_n,
  input logic [TOT-1:0]   stat_l0,
  input logic [TOT-1:0]   stat_l1,
  input logic [TOT-1:0]   mask_l0,
  input logic [TOT-1:0]   mask_l1,
  input logic [2*TOT-1:0] cfg
);

  logic [TOT-1:0] armed;
  always_comb
    for (int i = 0; i < TOT; i++) armed[i] = cfg[2*i] | cfg[2*i+1];

  p_idle_field_never_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat_l0 & ~$past(stat_l0)) | (stat_l1 & ~$past(stat_l1))) & ~$past(armed)) == '0);

  p_edge_reaches_both_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd || bus_wr) |-> ((stat_l0 & ~$past(stat_l0) & ~stat_l1) == '0));

  p_full_mask_line0_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_l0) |-> irq_n[0]);

  p_full_mask_line1_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_l1) |-> irq_n[1]);

  p_clear_only_by_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(($past(stat_l0) & ~stat_l0) | ($past(stat_l1) & ~stat_l1))) |-> $past(bus_rd || bus_wr));

endmodule

bind dl_irq_ctrl dl_irq_chk #(.TOT(NUM_BANKS*SRC_PER_BANK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .bus_rd  (bus_rd),
  .bus_wr  (bus_wr),
  .irq_n   (irq_n),
  .stat_l0 (stat_l0_all),
  .stat_l1 (stat_l1_all),
  .mask_l0 (mask_l0_all),
  .mask_l1 (mask_l1_all),
  .cfg     (cfg_all)
);

// File: tb/sim_dl_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dl_irq_ctrl;

  localparam int NB  = 2;
  localparam int SPB = 24;
  localparam int TOT = NB * SPB;
  localparam int AW  = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic [TOT-1:0] src;
  logic [AW-1:0]  addr;
  logic           wr, rd;
  logic [7:0]     wdata;
  wire  [7:0]     rdata;
  wire  [1:0]     irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  dl_irq_ctrl #(.NUM_BANKS(NB), .SRC_PER_BANK(SPB), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(addr),
    .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
  );

  function automatic int a_stat(int b, int l, int k); return b*32 + l*4 + k;     endfunction
  function automatic int a_mask(int b, int l, int k); return b*32 + 8 + l*4 + k; endfunction
  function automatic int a_edge(int b, int k);        return b*32 + 16 + k;      endfunction
  function automatic int a_ctrl(int b);               return b*32 + 24;          endfunction
  function automatic int a_pri(int l);                return NB*32 + l;          endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); addr = AW'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [7:0] d);
    @(negedge clk); addr = AW'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_src(input int s, input logic v);
    @(negedge clk); src[s] = v;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] got, exp;
    int b, j;
    string tag;
    rst_n = 1'b0; src = '0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq_n in reset", {6'd0, irq_n}, 8'h03);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset contents
    for (int bb = 0; bb < NB; bb++) begin
      for (int l = 0; l < 2; l++)
        for (int k = 0; k < 4; k++) begin
          rd_reg(a_mask(bb, l, k), got); chk("R1 mask", got, (k < 3) ? 8'hff : 8'h00);
          rd_reg(a_stat(bb, l, k), got); chk("R1 status", got, 8'h00);
        end
      for (int k = 0; k < 6; k++) begin
        rd_reg(a_edge(bb, k), got); chk("R1 edge", got, 8'h00);
      end
      rd_reg(a_ctrl(bb), got); chk("R1 ctrl", got, 8'h00);
    end
    rd_reg(a_pri(0), got); chk("R1 primary0", got, 8'h00);
    rd_reg(a_pri(1), got); chk("R1 primary1", got, 8'h00);

    // Sweep every source through every edge code (W1C mode, all masked)
    for (int s = 0; s < TOT; s++) begin
      for (int c = 0; c < 4; c++) begin
        b = s / SPB; j = s % SPB;
        tag = (c == 0) ? "R3" : "R2 R10";
        wr_reg(a_edge(b, j/4), c << ((j % 4) * 2));
        set_src(s, 1'b1);
        exp = c[1] ? 8'(1 << (j % 8)) : 8'h00;
        rd_reg(a_stat(b, 0, j/8), got); chk({tag, " rise line0"}, got, exp);
        rd_reg(a_stat(b, 1, j/8), got); chk("R4 rise line1", got, exp);
        chk("R5 masked quiet", {6'd0, irq_n}, 8'h03);
        wr_reg(a_stat(b, 0, j/8), 8'hff);
        wr_reg(a_stat(b, 1, j/8), 8'hff);
        set_src(s, 1'b0);
        exp = c[0] ? 8'(1 << (j % 8)) : 8'h00;
        rd_reg(a_stat(b, 0, j/8), got); chk({tag, " fall line0"}, got, exp);
        rd_reg(a_stat(b, 1, j/8), got); chk("R4 fall line1", got, exp);
        wr_reg(a_stat(b, 0, j/8), 8'hff);
        wr_reg(a_stat(b, 1, j/8), 8'hff);
        wr_reg(a_edge(b, j/4), 0);
      end
    end

    // Masking and primary summary: bank0 src5 and bank1 src5 (global 29)
    wr_reg(a_edge(0, 1), 8'h0c);
    wr_reg(a_edge(1, 1), 8'h0c);
    wr_reg(a_mask(0, 0, 0), 8'hdf);
    set_src(5, 1'b1);
    chk("R5 line0 asserted only", {6'd0, irq_n}, 8'h02);
    rd_reg(a_pri(0), got); chk("R11 primary0", got, 8'h01);
    rd_reg(a_pri(1), got); chk("R11 primary1", got, 8'h00);
    set_src(29, 1'b1);
    wr_reg(a_mask(1, 1, 0), 8'hdf);
    chk("R5 both asserted", {6'd0, irq_n}, 8'h00);
    rd_reg(a_pri(1), got); chk("R11 primary1 bank1", got, 8'h02);
    rd_reg(a_pri(0), got); chk("R11 primary0 bank1 masked", got, 8'h01);

    // W1C on line0 only
    wr_reg(a_stat(0, 0, 0), 8'h20);
    chk("R6 line0 released", {6'd0, irq_n}, 8'h01);
    rd_reg(a_stat(0, 0, 0), got); chk("R7 cleared", got, 8'h00);
    rd_reg(a_stat(0, 1, 0), got); chk("R6 line1 kept", got, 8'h20);
    wr_reg(a_stat(0, 1, 0), 8'h00);
    rd_reg(a_stat(0, 1, 0), got); chk("R7 write zero keeps", got, 8'h20);
    rd_reg(a_stat(0, 1, 0), got); chk("R7 read keeps", got, 8'h20);
    wr_reg(a_stat(0, 1, 0), 8'hff);
    wr_reg(a_stat(1, 0, 0), 8'hff);
    wr_reg(a_stat(1, 1, 0), 8'hff);
    chk("R5 all released", {6'd0, irq_n}, 8'h03);

    // Clear-on-read mode in bank0
    wr_reg(a_ctrl(0), 1);
    rd_reg(a_ctrl(0), got); chk("R10 ctrl readback", got, 8'h01);
    repeat (2) @(negedge clk);
    chk("R12 read data held", rdata, 8'h01);
    set_src(5, 1'b0);
    wr_reg(a_stat(0, 0, 0), 8'hff);
    rd_reg(a_stat(0, 0, 0), got); chk("R8 write ignored", got, 8'h20);
    rd_reg(a_stat(0, 0, 0), got); chk("R8 read cleared", got, 8'h00);
    rd_reg(a_stat(0, 1, 0), got); chk("R6 other line pending", got, 8'h20);
    rd_reg(a_stat(0, 1, 0), got); chk("R8 line1 read cleared", got, 8'h00);

    // R9: edge in the same cycle as a clearing read
    set_src(5, 1'b1);
    @(negedge clk); addr = AW'(a_stat(0, 0, 0)); rd = 1'b1; src[5] = 1'b0;
    @(negedge clk); rd = 1'b0; got = rdata;
    chk("R9 read shows old", got, 8'h20);
    rd_reg(a_stat(0, 0, 0), got); chk("R9 set beats read clear", got, 8'h20);
    rd_reg(a_stat(0, 0, 0), got); chk("R9 then cleared", got, 8'h00);

    // R9: edge in the same cycle as a clearing write
    wr_reg(a_ctrl(0), 0);
    set_src(5, 1'b1);
    @(negedge clk); addr = AW'(a_stat(0, 0, 0)); wdata = 8'hff; wr = 1'b1; src[5] = 1'b0;
    @(negedge clk); wr = 1'b0;
    rd_reg(a_stat(0, 0, 0), got); chk("R9 set beats write clear", got, 8'h20);
    chk("R5 unmasked pending", {6'd0, irq_n}, 8'h02);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule